// File: doc/BRIEF.md
# Descriptor-driven configuration DMA engine

This block is a bus master that moves bytes of configuration items between an item store and system memory. Software builds a 16-byte descriptor in memory and writes its 64-bit address to a trigger register. The engine then fetches the descriptor, can switch the current item, runs a read, write or skip pass over the requested length, and finally overwrites the descriptor's control word with a status value.

The current item key and byte offset are held in one shared cursor. A byte-wide selector port outside this block also drives that cursor. A read that runs past the end of the item, or that targets an item that does not exist, pads memory with zero bytes. Refused writes and memory faults end the pass with an error status. While a transfer is in progress, the engine reports busy, and it ignores new triggers and selector writes.

Memory is reached through a request/ready port with 32-bit beats. Item bytes come from a combinational lookup on the cursor.

Top module: `cfg_dma_engine`

## Requirements
- R1: A trigger write with `trg_size`=4 and `trg_off`=0 sets the descriptor pointer to {wdata[31:0], 32'h0} and does not start a transfer. A write with size 4 at offset 4 ORs wdata[31:0] into the low half of the pointer and starts a transfer. A write with size 8 at offset 0 replaces the whole pointer and starts a transfer. All other sizes and offsets are ignored.
- R2: `trg_rdata` returns `trg_size` bytes of the constant 0x51454D5520434647, right-aligned. Offset 0 addresses the most significant byte. A slice that runs past byte 7 returns zero.
- R3: `busy` is high from the cycle after a starting trigger write until the status write completes, and `mem_req` is never high while `busy` is low. Trigger writes and selector writes that arrive while `busy` is high are ignored.
- R4: The descriptor is fetched with four aligned word reads. Byte offset +0 holds the control word, +4 the length, +8 the upper address word and +12 the lower address word. All are big-endian.
- R5: When control bit 3 (0x08) is set, the item key is loaded from control bits 31:16 and the offset is cleared before any data moves.
- R6: The operation is picked by priority: read (0x02) over write (0x10) over skip (0x04). With none of these bits set, no data moves and the status is 0.
- R7: A read copies item bytes to consecutive memory addresses and advances the offset by one for each byte taken. Once the item is exhausted or absent, it writes zero bytes for the rest of the length, with no error.
- R8: A write copies memory bytes into the item at the offset. If the item is absent, exhausted or not writable, the pass stops with the error status.
- R9: A skip advances the offset by the smaller of the remaining length and the bytes left in the item, and moves no data. On an absent or exhausted item it does nothing and reports no error.
- R10: A memory error on a data beat stops the pass with the error status. Bytes moved before the error stay in place.
- R11: On completion the word at the descriptor address is written with 0x00000001 on error and 0x00000000 otherwise. A faulted descriptor fetch moves no data and writes 0x00000001.
- R12: The byte at address A travels in the beat at address A with bits 1:0 cleared. It sits in bits [31-8*(A%4) -: 8], with `mem_be` bit 3-(A%4) set. The request holds its address and enables until `mem_ready`.
- R13: Reset leaves the key at `RESET_KEY` and the offset at 0. A selector write while idle loads the key and clears the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trg_we | input | 1 | Trigger register write strobe |
| trg_off | input | 3 | Byte offset of the trigger access |
| trg_size | input | 4 | Byte count of the trigger access |
| trg_wdata | input | 64 | Trigger write data, right-aligned |
| trg_rdata | output | 64 | Signature slice for the current offset and size |
| sel_we | input | 1 | Selector write strobe |
| sel_key | input | KEY_W | Key from the selector port |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 64 | Word-aligned beat address |
| mem_be | output | 4 | Byte enables, bit 3 is the lowest address |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Beat accepted or completed |
| mem_rdata | input | 32 | Read beat data, valid with ready |
| mem_err | input | 1 | Beat failed, valid with ready |
| item_key | output | KEY_W | Current item key |
| item_off | output | 32 | Current byte offset in the item |
| item_valid | input | 1 | Item at item_key exists |
| item_len | input | 32 | Length of the current item |
| item_wr_ok | input | 1 | Current item accepts writes |
| item_rdata | input | 8 | Item byte at item_key/item_off |
| item_we | output | 1 | Item byte write strobe |
| item_wdata | output | 8 | Item byte to store |

## Verification
The assertions assume that `mem_ready` only comes while `mem_req` is high and lasts one cycle per beat. They also assume that the item inputs stay stable while a beat is pending, and that descriptor addresses are 4-byte aligned. The bench meets these assumptions by construction. Its memory responder answers only pending requests, deasserts ready on the next half cycle and varies its latency from 0 to 2 cycles. Its item store changes only on a granted item write. Every descriptor it uses sits on a word boundary, while the data addresses are unaligned on purpose. Memory faults are produced by addresses at or above 4096, which also lets the bench cause a fetch fault through a nonzero upper pointer half.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

  localparam logic [63:0] SIGNATURE = 64'h5145_4D55_2043_4647;

  // control flag positions
  localparam int F_ERR   = 0;
  localparam int F_READ  = 1;
  localparam int F_SKIP  = 2;
  localparam int F_SEL   = 3;
  localparam int F_WRITE = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_DECODE, ST_MOVE, ST_WBACK} eng_state_t;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_SKIP} op_t;

  // signature bytes [off .. off+size-1], MSB first, right-aligned
  function automatic logic [63:0] sig_slice(input logic [2:0] off, input logic [3:0] size);
    logic [63:0] v;
    int          e;
    v = '0;
    e = int'(off) + int'(size);
    if (size != 4'd0 && e <= 8) begin
      v = SIGNATURE >> (8 * (8 - e));
      if (size < 4'd8) v = v & ((64'd1 << (8 * int'(size))) - 64'd1);
    end
    return v;
  endfunction

  function automatic op_t op_pick(input logic [31:0] c);
    if (c[F_READ])       return OP_READ;
    else if (c[F_WRITE]) return OP_WRITE;
    else if (c[F_SKIP])  return OP_SKIP;
    else                 return OP_NONE;
  endfunction

  // bytes a skip step consumes; caller guarantees off < ilen
  function automatic logic [31:0] chunk_len(input logic [31:0] rem, input logic [31:0] ilen,
                                            input logic [31:0] off);
    logic [31:0] left;
    left = ilen - off;
    return (rem < left) ? rem : left;
  endfunction

  function automatic logic [63:0] beat_addr(input logic [63:0] a);
    return {a[63:2], 2'b00};
  endfunction

  function automatic logic [3:0] lane_be(input logic [1:0] a);
    return 4'b1000 >> a;
  endfunction

  function automatic logic [31:0] lane_put(input logic [7:0] b, input logic [1:0] a);
    return {b, 24'h0} >> {a, 3'b000};
  endfunction

  function automatic logic [7:0] lane_get(input logic [31:0] w, input logic [1:0] a);
    logic [31:0] t;
    t = w << {a, 3'b000};
    return t[31:24];
  endfunction

endpackage

// File: rtl/cfg_dma_doorbell.sv
module cfg_dma_doorbell
  import cfg_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trg_we,
  input  logic [2:0]  trg_off,
  input  logic [3:0]  trg_size,
  input  logic [63:0] trg_wdata,
  input  logic        accept,
  output logic [63:0] trg_rdata,
  output logic [63:0] desc_addr,
  output logic        kick
);

  logic ld_hi, ld_lo, ld_full;

  assign ld_hi   = trg_we && accept && (trg_size == 4'd4) && (trg_off == 3'd0);
  assign ld_lo   = trg_we && accept && (trg_size == 4'd4) && (trg_off == 3'd4);
  assign ld_full = trg_we && accept && (trg_size == 4'd8) && (trg_off == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_addr <= '0;
      kick      <= 1'b0;
    end else begin
      if (ld_hi)        desc_addr <= {trg_wdata[31:0], 32'h0};
      else if (ld_lo)   desc_addr <= desc_addr | {32'h0, trg_wdata[31:0]};
      else if (ld_full) desc_addr <= trg_wdata;
      kick <= ld_lo | ld_full;
    end
  end

  assign trg_rdata = sig_slice(trg_off, trg_size);

  // R1
  kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> $past(trg_we && accept));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(desc_addr));

endmodule

// File: rtl/cfg_dma_cursor.sv
module cfg_dma_cursor #(
  parameter int          KEY_W     = 16,
  parameter logic [KEY_W-1:0] RESET_KEY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic [KEY_W-1:0] host_key,
  input  logic             eng_sel,
  input  logic [KEY_W-1:0] eng_key,
  input  logic             adv,
  input  logic [31:0]      adv_n,
  output logic [KEY_W-1:0] key,
  output logic [31:0]      off
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key <= RESET_KEY;
      off <= '0;
    end else if (host_sel) begin
      key <= host_key;
      off <= '0;
    end else if (eng_sel) begin
      key <= eng_key;
      off <= '0;
    end else if (adv) begin
      off <= off + adv_n;
    end
  end

  // R5
  sel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel || eng_sel) |=> (off == 32'd0));

  // R13
  cursor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && !eng_sel && !adv) |=> ($stable(off) && $stable(key)));

endmodule

// File: rtl/cfg_dma_core.sv
module cfg_dma_core
  import cfg_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kick,
  input  logic [63:0] desc_addr,
  output logic        eng_busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  input  logic [31:0] item_off,
  input  logic        item_valid,
  input  logic [31:0] item_len,
  input  logic        item_wr_ok,
  input  logic [7:0]  item_rdata,
  output logic        item_we,
  output logic [7:0]  item_wdata,
  output logic        eng_sel,
  output logic [15:0] eng_key,
  output logic        adv,
  output logic [31:0] adv_n
);

  eng_state_t  st;
  op_t         op;
  logic [1:0]  beat;
  logic [31:0] ctrl, rem;
  logic [63:0] dptr, dst;
  logic        err_q;

  // named internal events
  logic        item_end, beat_ok, beat_bad, wr_refused;
  logic [31:0] skip_n;

  assign item_end   = !item_valid || (item_off >= item_len);
  assign beat_ok    = mem_req && mem_ready && !mem_err;
  assign beat_bad   = mem_req && mem_ready && mem_err;
  assign skip_n     = chunk_len(rem, item_len, item_off);
  assign wr_refused = (st == ST_MOVE) && (op == OP_WRITE) && (rem != 32'd0) &&
                      (item_end || !item_wr_ok);
  assign eng_busy   = (st != ST_IDLE);
  assign eng_key    = ctrl[31:16];

  always_comb begin
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_be     = 4'h0;
    mem_wdata  = '0;
    item_we    = 1'b0;
    item_wdata = 8'h00;
    adv        = 1'b0;
    adv_n      = 32'd1;
    eng_sel    = 1'b0;
    case (st)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = beat_addr(dptr + {60'd0, beat, 2'b00});
        mem_be   = 4'hF;
      end
      ST_DECODE: eng_sel = ctrl[F_SEL];
      ST_MOVE: begin
        if (rem != 32'd0) begin
          case (op)
            OP_READ: begin
              mem_req   = 1'b1;
              mem_we    = 1'b1;
              mem_addr  = beat_addr(dst);
              mem_be    = lane_be(dst[1:0]);
              mem_wdata = lane_put(item_end ? 8'h00 : item_rdata, dst[1:0]);
              adv       = beat_ok && !item_end;
            end
            OP_WRITE: begin
              if (!wr_refused) begin
                mem_req    = 1'b1;
                mem_addr   = beat_addr(dst);
                mem_be     = lane_be(dst[1:0]);
                item_we    = beat_ok;
                item_wdata = lane_get(mem_rdata, dst[1:0]);
                adv        = beat_ok;
              end
            end
            OP_SKIP: begin
              adv   = !item_end;
              adv_n = skip_n;
            end
            default: ;
          endcase
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = beat_addr(dptr);
        mem_be    = 4'hF;
        mem_wdata = {31'd0, err_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      op    <= OP_NONE;
      beat  <= '0;
      ctrl  <= '0;
      rem   <= '0;
      dptr  <= '0;
      dst   <= '0;
      err_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (kick) begin
            dptr  <= desc_addr;
            beat  <= '0;
            err_q <= 1'b0;
            st    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (beat_bad) begin
            err_q <= 1'b1;
            st    <= ST_WBACK;
          end else if (beat_ok) begin
            case (beat)
              2'd0: ctrl <= mem_rdata;
              2'd1: rem  <= mem_rdata;
              2'd2: dst[63:32] <= mem_rdata;
              default: dst[31:0] <= mem_rdata;
            endcase
            beat <= beat + 2'd1;
            if (beat == 2'd3) st <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          op <= op_pick(ctrl);
          st <= (op_pick(ctrl) == OP_NONE) ? ST_WBACK : ST_MOVE;
        end
        ST_MOVE: begin
          if (rem == 32'd0) begin
            st <= ST_WBACK;
          end else begin
            case (op)
              OP_READ, OP_WRITE: begin
                if (wr_refused || beat_bad) begin
                  err_q <= 1'b1;
                  st    <= ST_WBACK;
                end else if (beat_ok) begin
                  dst <= dst + 64'd1;
                  rem <= rem - 32'd1;
                end
              end
              OP_SKIP: rem <= item_end ? 32'd0 : (rem - skip_n);
              default: st <= ST_WBACK;
            endcase
          end
        end
        ST_WBACK: if (mem_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

  // R8
  item_wr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    item_we |-> (item_valid && item_wr_ok && (item_off < item_len)));

  // R10
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MOVE && beat_bad) |=> (st == ST_WBACK && err_q));

  // R11
  wback_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WBACK && mem_ready) |=> !eng_busy);

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
#(
  parameter int               KEY_W     = 16,
  parameter logic [KEY_W-1:0] RESET_KEY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trg_we,
  input  logic [2:0]       trg_off,
  input  logic [3:0]       trg_size,
  input  logic [63:0]      trg_wdata,
  output logic [63:0]      trg_rdata,
  input  logic             sel_we,
  input  logic [KEY_W-1:0] sel_key,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_err,
  output logic [KEY_W-1:0] item_key,
  output logic [31:0]      item_off,
  input  logic             item_valid,
  input  logic [31:0]      item_len,
  input  logic             item_wr_ok,
  input  logic [7:0]       item_rdata,
  output logic             item_we,
  output logic [7:0]       item_wdata
);

  logic        kick, eng_busy, eng_sel, adv;
  logic [63:0] desc_addr;
  logic [15:0] eng_key;
  logic [31:0] adv_n;

  assign busy = eng_busy | kick;

  cfg_dma_doorbell u_bell (
    .clk, .rst_n, .trg_we, .trg_off, .trg_size, .trg_wdata,
    .accept(!busy), .trg_rdata, .desc_addr, .kick
  );

  cfg_dma_cursor #(.KEY_W(KEY_W), .RESET_KEY(RESET_KEY)) u_cursor (
    .clk, .rst_n,
    .host_sel(sel_we && !busy), .host_key(sel_key),
    .eng_sel, .eng_key(eng_key[KEY_W-1:0]),
    .adv, .adv_n, .key(item_key), .off(item_off)
  );

  cfg_dma_core u_core (
    .clk, .rst_n, .kick, .desc_addr, .eng_busy,
    .mem_req, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_ready, .mem_rdata, .mem_err,
    .item_off, .item_valid, .item_len, .item_wr_ok, .item_rdata, .item_we, .item_wdata,
    .eng_sel, .eng_key, .adv, .adv_n
  );

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

endmodule

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trg_we = 1'b0;
  logic [2:0]  trg_off = '0;
  logic [3:0]  trg_size = '0;
  logic [63:0] trg_wdata = '0;
  logic [63:0] trg_rdata;
  logic        sel_we = 1'b0;
  logic [15:0] sel_key = '0;
  logic        busy, mem_req, mem_we, item_we;
  logic [63:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, item_off, item_len;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] item_key;
  logic        item_valid, item_wr_ok;
  logic [7:0]  item_rdata, item_wdata;

  always #4 clk = ~clk;  // 125 MHz

  cfg_dma_engine u_dut (.*);

  int vectors = 0, fails = 0;

  // behavioural stores: actual (driven by DUT) and expected (driven by model)
  logic [7:0]  m  [0:4095];
  logic [7:0]  em [0:4095];
  logic [7:0]  itm  [0:3][0:15];
  logic [7:0]  eitm [0:3][0:15];
  logic [31:0] ilen [0:3] = '{32'd4, 32'd10, 32'd8, 32'd6};
  logic        iwr  [0:3] = '{1'b0, 1'b0, 1'b0, 1'b1};
  int          mk = 0, mo = 0;
  logic [63:0] last_wa = '0;
  logic [31:0] last_wd = '0;
  int          lat_cnt = 0, lat_seq = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always_comb begin
    item_valid = (item_key < 16'd4);
    item_len   = item_valid ? ilen[item_key[1:0]] : 32'd0;
    item_wr_ok = item_valid && iwr[item_key[1:0]];
    item_rdata = (item_valid && item_off < 32'd16) ? itm[item_key[1:0]][item_off[3:0]] : 8'h00;
  end

  // memory responder
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req && rst_n) begin
      if (lat_cnt == 0) begin
        mem_ready = 1'b1;
        mem_err   = (mem_addr >= 64'd4096);
        if (!mem_err)
          mem_rdata = {m[mem_addr[11:0]], m[mem_addr[11:0]+1], m[mem_addr[11:0]+2], m[mem_addr[11:0]+3]};
        else
          mem_rdata = 32'hDEAD_BEEF;
        lat_cnt = lat_seq;
        lat_seq = (lat_seq + 1) % 3;
      end else begin
        lat_cnt--;
      end
    end
  end

  // commit DUT writes
  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) begin
      last_wa = mem_addr;
      last_wd = mem_wdata;
      if (!mem_err)
        for (int l = 0; l < 4; l++)
          if (mem_be[3-l]) m[mem_addr[11:0]+l] = mem_wdata[31-8*l -: 8];
    end
    if (item_we && item_key < 16'd4 && item_off < 32'd16)
      itm[item_key[1:0]][item_off[3:0]] = item_wdata;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) chk(busy || !mem_req, "R3", "request while idle", mem_req, 0);
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic trig(input logic [2:0] off, input logic [3:0] size, input logic [63:0] d);
    @(negedge clk);
    trg_we = 1'b1; trg_off = off; trg_size = size; trg_wdata = d;
    @(negedge clk);
    trg_we = 1'b0; trg_off = 3'd0; trg_size = 4'd8;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic put_be32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      m[a+i]  = v[31-8*i -: 8];
      em[a+i] = v[31-8*i -: 8];
    end
  endtask

  // behavioural transfer model, byte by byte
  task automatic model(input logic [31:0] ctrl, input int len, input int dst, output bit err);
    int op;
    err = 0;
    if (ctrl[3]) begin mk = int'(ctrl[31:16]); mo = 0; end
    op = ctrl[1] ? 1 : ctrl[4] ? 2 : ctrl[2] ? 3 : 0;
    for (int i = 0; i < len && op != 0; i++) begin
      bit inr;
      inr = (mk < 4) && (mo < int'(ilen[mk]));
      if (op == 1) begin
        if (dst + i >= 4096) begin err = 1; break; end
        em[dst+i] = inr ? eitm[mk][mo] : 8'h00;
        if (inr) mo++;
      end else if (op == 2) begin
        if (!inr || !iwr[mk]) begin err = 1; break; end
        if (dst + i >= 4096) begin err = 1; break; end
        eitm[mk][mo] = em[dst+i];
        mo++;
      end else if (inr) begin
        mo++;
      end
    end
  endtask

  task automatic compare(input string req);
    int dm, di;
    dm = 0; di = 0;
    for (int i = 0; i < 4096; i++) if (m[i] !== em[i]) dm++;
    for (int k = 0; k < 4; k++) for (int j = 0; j < 16; j++) if (itm[k][j] !== eitm[k][j]) di++;
    chk(dm == 0, req, "memory bytes differing", dm, 0);
    chk(di == 0, req, "item bytes differing", di, 0);
    chk(int'(item_key) == mk, req, "item key", item_key, mk);
    chk(int'(item_off) == mo, req, "item offset", item_off, mo);
  endtask

  // mode 0: 8-byte trigger; 1: low-half trigger with lo; 2: 8-byte trigger plus pokes while busy
  task automatic run(input string req, input longint d, input logic [31:0] ctrl, input int len,
                     input int dst, input int mode, input logic [31:0] lo);
    bit err;
    if (d < 4096) begin
      put_be32(int'(d), ctrl);
      put_be32(int'(d) + 4, len);
      put_be32(int'(d) + 8, 32'h0);
      put_be32(int'(d) + 12, dst);
      model(ctrl, len, dst, err);
      em[d] = 0; em[d+1] = 0; em[d+2] = 0; em[d+3] = {7'd0, err};
    end
    if (mode == 1) trig(3'd4, 4'd4, {32'h0, lo});
    else           trig(3'd0, 4'd8, d);
    chk(busy === 1'b1, "R3", "busy after start", busy, 1);
    if (mode == 2) begin
      trg_we = 1'b1; trg_off = 3'd0; trg_size = 4'd8; trg_wdata = 64'h300;
      sel_we = 1'b1; sel_key = 16'd2;
      @(negedge clk);
      trg_we = 1'b0; sel_we = 1'b0;
    end
    wait_idle();
    repeat (3) @(negedge clk);
    chk(!busy, req, "no further transfer", busy, 0);
    if (d < 4096)
      chk({m[d], m[d+1], m[d+2], m[d+3]} == {24'd0, 7'd0, err}, {req, " R4 R11"}, "status word",
          {m[d], m[d+1], m[d+2], m[d+3]}, err);
    compare(req);
  endtask

  function automatic logic [31:0] cw(input int key, input logic [7:0] flags);
    return {key[15:0], 8'h00, flags};
  endfunction

  task automatic sig(input logic [2:0] off, input logic [3:0] size, input logic [63:0] exp);
    @(negedge clk);
    trg_off = off; trg_size = size;
    #1;
    chk(trg_rdata == exp, "R2", "signature slice", trg_rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin m[i] = 8'(i * 7 + 3); em[i] = m[i]; end
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 16; j++) begin itm[k][j] = 8'(16 * (k + 1) * 4 + j); eitm[k][j] = itm[k][j]; end
    put_be32(12'h300, 32'hAAAA_5555);  // sentinel where a poked trigger would point
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!busy, "R13", "busy after reset", busy, 0);
    chk(item_key == 16'd0 && item_off == 32'd0, "R13", "cursor after reset", item_off, 0);

    sig(3'd0, 4'd8, 64'h5145_4D55_2043_4647);
    sig(3'd4, 4'd4, 64'h2043_4647);
    sig(3'd0, 4'd4, 64'h5145_4D55);
    sig(3'd3, 4'd1, 64'h55);
    sig(3'd6, 4'd2, 64'h4647);
    sig(3'd6, 4'd4, 64'h0);

    // R5 R7 R12: select and read at unaligned destination
    run("R5 R7 R12", 12'h100, cw(1, 8'h0A), 6, 12'h401, 0, 0);
    // R7: read through end of item, zero pad
    run("R7", 12'h100, cw(0, 8'h02), 8, 12'h40E, 0, 0);
    // R9: skip then read, then skip past end
    run("R9", 12'h100, cw(2, 8'h0C), 3, 0, 0, 0);
    run("R9 R7", 12'h100, cw(0, 8'h02), 2, 12'h423, 0, 0);
    run("R9", 12'h100, cw(0, 8'h04), 100, 0, 0, 0);
    run("R9", 12'h100, cw(0, 8'h04), 5, 0, 0, 0);
    // R8: write into writable item, refused item, past end
    run("R8", 12'h100, cw(3, 8'h18), 4, 12'h431, 0, 0);
    run("R8", 12'h100, cw(0, 8'h18), 2, 12'h440, 0, 0);
    run("R8", 12'h100, cw(3, 8'h18), 8, 12'h445, 0, 0);
    // R7: absent item reads as zeros
    run("R7", 12'h100, cw(9, 8'h0A), 4, 12'h452, 0, 0);
    // R10: memory fault mid read
    run("R10", 12'h100, cw(1, 8'h0A), 4, 4094, 0, 0);
    // R6: no operation, select only; priority
    run("R6", 12'h100, cw(2, 8'h08), 3, 12'h460, 0, 0);
    run("R6", 12'h100, cw(1, 8'h1E), 2, 12'h466, 0, 0);
    run("R6", 12'h100, cw(3, 8'h1C), 2, 12'h46B, 0, 0);

    // R1: upper half alone does not start
    trig(3'd0, 4'd4, 64'h0);
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "upper half write started", busy, 0);
    run("R1", 12'h100, cw(1, 8'h0A), 2, 12'h480, 1, 32'h100);
    // low half ORs: 0x100 | 0x040
    put_be32(12'h040, 32'hFFFF_FFFF);
    run("R1", 12'h140, cw(0, 8'h02), 2, 12'h490, 1, 32'h040);
    trig(3'd0, 4'd2, 64'h180);
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "2-byte trigger ignored", busy, 0);
    trig(3'd4, 4'd8, 64'h180);
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "8-byte trigger at 4 ignored", busy, 0);
    trig(3'd2, 4'd4, 64'h180);
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "4-byte trigger at 2 ignored", busy, 0);
    // R11: nonzero upper half points outside memory, fetch faults
    trig(3'd0, 4'd4, 64'h1);
    run("R1 R11", 64'h1_0000_0100, 32'h0, 0, 0, 1, 32'h100);
    chk(last_wa == 64'h1_0000_0100 && last_wd == 32'h1, "R11", "fault status write",
        last_wd, 1);

    // R3: trigger and selector writes while busy are ignored
    run("R3", 12'h180, cw(1, 8'h0A), 10, 12'h4A0, 2, 0);

    // R13: idle selector write
    @(negedge clk);
    sel_we = 1'b1; sel_key = 16'd2;
    @(negedge clk);
    sel_we = 1'b0;
    mk = 2; mo = 0;
    chk(item_key == 16'd2 && item_off == 32'd0, "R13", "selector write when idle", item_key, 2);
    run("R13 R7", 12'h100, cw(0, 8'h02), 3, 12'h4C0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule